// File: doc/BRIEF.md
# CPU Status and Exception-Context Registers

This block holds the system control state of a small processor core. It keeps the status word, which holds the condition flag, the saturation enable, the two divide-step bits, a four-bit interrupt mask, the register-bank select, the exception-block bit and the privilege bit. It also keeps a vector base address and one saved-context pair: a saved program counter and a saved status word. The surrounding pipeline asserts an exception-accept strobe together with the current PC and a vector offset. The block stores the context, raises the privilege and block bits, and presents the handler fetch address. A return strobe puts the saved status back and exposes the saved PC so the fetch unit can resume.

Software writes to the status word and to the vector base are honoured only while the privilege bit is set. A write attempted outside privileged mode is discarded, and the block reports it with a one-cycle violation pulse. The datapath may update the condition flag and the divide-step bits in any mode. A combinational gate compares an incoming interrupt level against the live mask and block bit and returns the accept decision.

Top module: `ctx_status_regs`

## Requirements
- R1: After reset the status word reads 0x7F0: privilege 1, bank 1, block 1, mask 15, and the T, S, M and Q bits 0. The vector base, the saved PC (`rte_pc`) and `priv_viol` all read 0.
- R2: The status word encoding has bit 10 = privilege, bit 9 = bank, bit 8 = block, bits 7:4 = mask, bit 3 = M, bit 2 = Q, bit 1 = S and bit 0 = T. Each field output equals its bit in `sr_word`.
- R3: An SR write made in privileged mode, with no exception or return in the same cycle, replaces the whole status word from the next cycle.
- R4: An SR write or vector-base write made outside privileged mode is dropped. `priv_viol` is high in exactly the following cycle and low again one cycle later.
- R5: On exception accept, the saved PC takes `exc_pc` and the saved status takes the current status word. The status word keeps its other fields but gets privilege 1 and block 1. Only one pair exists, so a second exception overwrites it.
- R6: On return-from-exception the status word is loaded from the saved status. `rte_pc` always shows the saved PC.
- R7: Precedence within a cycle is exception accept, then return, then an honoured SR write, then flag updates. An exception together with a return behaves as the exception alone.
- R8: `handler_addr` equals the vector base plus the zero-extended `exc_vofs`, modulo 2^ADDR_W, and is combinational.
- R9: `irq_accept` is 1 exactly when the block bit is 0 and `irq_level` is strictly greater than the mask.
- R10: `t_upd_en` loads T and `dv_upd_en` loads M and Q, in any privilege mode, unless a higher-precedence status change occurs in the same cycle.
- R11: A vector-base write made in privileged mode takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| exc_take | input | 1 | exception/interrupt accepted this cycle |
| exc_pc | input | ADDR_W | PC to save on entry |
| exc_vofs | input | VOFS_W | vector offset for the handler address |
| rte_go | input | 1 | return-from-exception command |
| sr_wr_en | input | 1 | software write of the status word |
| sr_wr_data | input | 11 | status word value to write |
| vbr_wr_en | input | 1 | software write of the vector base |
| vbr_wr_data | input | ADDR_W | vector base value to write |
| t_upd_en | input | 1 | datapath update of T |
| t_upd_val | input | 1 | new T value |
| dv_upd_en | input | 1 | divide-step update of M and Q |
| dv_m | input | 1 | new M value |
| dv_q | input | 1 | new Q value |
| irq_level | input | 4 | pending interrupt level |
| sr_word | output | 11 | live status word |
| flag_t | output | 1 | condition flag for branches |
| flag_s | output | 1 | saturation enable |
| flag_m | output | 1 | divide-step M bit |
| flag_q | output | 1 | divide-step Q bit |
| int_mask | output | 4 | interrupt mask |
| reg_bank | output | 1 | register bank select |
| exc_block | output | 1 | exception block bit |
| priv_mode | output | 1 | privilege bit |
| handler_addr | output | ADDR_W | handler fetch address |
| rte_pc | output | ADDR_W | saved PC for resumption |
| irq_accept | output | 1 | interrupt accept decision |
| priv_viol | output | 1 | one-cycle privilege-violation pulse |

## Verification
The bench builds the block with ADDR_W = 16 and VOFS_W = 8. With these values, all 2048 status-word encodings can be written and read back. Every one that clears privilege is then probed with a dropped write and recovered through an exception. The full 256-entry offset range is swept against vector bases near 0xFFFF, which brings the address wrap into reach. The interrupt gate is swept over every mask, level and block combination, and the precedence cases are driven one at a time.

// File: rtl/ctxreg_pkg.sv
package ctxreg_pkg;
    localparam int MASK_W = 4;

    // status word layout, MSB first
    typedef struct packed {
        logic              priv;
        logic              bank;
        logic              blk;
        logic [MASK_W-1:0] imask;
        logic              m;
        logic              q;
        logic              s;
        logic              t;
    } sr_t;

    localparam int SR_W = $bits(sr_t);

    localparam sr_t SR_RESET = '{priv: 1'b1, bank: 1'b1, blk: 1'b1,
                                 imask: {MASK_W{1'b1}},
                                 m: 1'b0, q: 1'b0, s: 1'b0, t: 1'b0};
endpackage

// File: rtl/sr_core.sv
module sr_core
    import ctxreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_take,
    input  logic rte_go,
    input  logic sr_wr_en,
    input  sr_t  sr_wr_val,
    input  logic vbr_wr_en,
    input  logic t_upd_en,
    input  logic t_upd_val,
    input  logic dv_upd_en,
    input  logic dv_m,
    input  logic dv_q,
    input  sr_t  ssr_val,
    output sr_t  sr_o,
    output logic priv_viol
);
    typedef struct packed {
        sr_t  sr;
        logic viol;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.viol = (sr_wr_en || vbr_wr_en) && !st_q.sr.priv;
        if (exc_take) begin
            st_d.sr.priv = 1'b1;
            st_d.sr.blk  = 1'b1;
        end else if (rte_go) begin
            st_d.sr = ssr_val;
        end else if (sr_wr_en && st_q.sr.priv) begin
            st_d.sr = sr_wr_val;
        end else begin
            if (t_upd_en) begin
                st_d.sr.t = t_upd_val;
            end
            if (dv_upd_en) begin
                st_d.sr.m = dv_m;
                st_d.sr.q = dv_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr   <= SR_RESET;
            st_q.viol <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o      = st_q.sr;
    assign priv_viol = st_q.viol;

    // R5
    exc_entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (sr_o.priv && sr_o.blk));

    // R4
    nonpriv_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !sr_o.priv) |=> priv_viol);

    // R4
    nonpriv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !sr_o.priv && !exc_take && !rte_go) |=> $stable(sr_o.imask));

    // R6
    rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_go && !exc_take) |=> (sr_o == $past(ssr_val)));

    // R3
    priv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && sr_o.priv && !exc_take && !rte_go) |=> (sr_o == $past(sr_wr_val)));
endmodule

// File: rtl/exc_save.sv
module exc_save
    import ctxreg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_take,
    input  logic [ADDR_W-1:0] pc_in,
    input  sr_t               sr_in,
    output logic [ADDR_W-1:0] spc_o,
    output sr_t               ssr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] spc;
        sr_t               ssr;
    } sv_t;

    sv_t sv_d, sv_q;

    always_comb begin
        sv_d = sv_q;
        if (exc_take) begin
            sv_d.spc = pc_in;
            sv_d.ssr = sr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
        end else begin
            sv_q <= sv_d;
        end
    end

    assign spc_o = sv_q.spc;
    assign ssr_o = sv_q.ssr;

    // R5
    save_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> ((spc_o == $past(pc_in)) && (ssr_o == $past(sr_in))));

    // R5
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take |=> ($stable(spc_o) && $stable(ssr_o)));
endmodule

// File: rtl/vbr_core.sv
module vbr_core #(
    parameter int ADDR_W = 32,
    parameter int VOFS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv,
    input  logic              vbr_wr_en,
    input  logic [ADDR_W-1:0] vbr_wr_data,
    input  logic [VOFS_W-1:0] vofs,
    output logic [ADDR_W-1:0] handler_addr
);
    logic [ADDR_W-1:0] vbr_d, vbr_q;

    always_comb begin
        vbr_d = vbr_q;
        if (vbr_wr_en && priv) begin
            vbr_d = vbr_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbr_q <= '0;
        end else begin
            vbr_q <= vbr_d;
        end
    end

    assign handler_addr = vbr_q + ADDR_W'(vofs);

    // R11
    vbr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbr_wr_en && priv) |=> (vbr_q == $past(vbr_wr_data)));

    // R4
    vbr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vbr_wr_en && priv) |=> $stable(vbr_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import ctxreg_pkg::*;
(
    input  logic              blk,
    input  logic [MASK_W-1:0] imask,
    input  logic [MASK_W-1:0] level,
    output logic              accept
);
    always_comb begin
        accept = !blk && (level > imask);
    end
endmodule

// File: rtl/ctx_status_regs.sv
module ctx_status_regs
    import ctxreg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VOFS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_take,
    input  logic [ADDR_W-1:0] exc_pc,
    input  logic [VOFS_W-1:0] exc_vofs,
    input  logic              rte_go,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              vbr_wr_en,
    input  logic [ADDR_W-1:0] vbr_wr_data,
    input  logic              t_upd_en,
    input  logic              t_upd_val,
    input  logic              dv_upd_en,
    input  logic              dv_m,
    input  logic              dv_q,
    input  logic [MASK_W-1:0] irq_level,
    output logic [SR_W-1:0]   sr_word,
    output logic              flag_t,
    output logic              flag_s,
    output logic              flag_m,
    output logic              flag_q,
    output logic [MASK_W-1:0] int_mask,
    output logic              reg_bank,
    output logic              exc_block,
    output logic              priv_mode,
    output logic [ADDR_W-1:0] handler_addr,
    output logic [ADDR_W-1:0] rte_pc,
    output logic              irq_accept,
    output logic              priv_viol
);
    sr_t sr_cur;
    sr_t ssr_cur;

    sr_core u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_take  (exc_take),
        .rte_go    (rte_go),
        .sr_wr_en  (sr_wr_en),
        .sr_wr_val (sr_t'(sr_wr_data)),
        .vbr_wr_en (vbr_wr_en),
        .t_upd_en  (t_upd_en),
        .t_upd_val (t_upd_val),
        .dv_upd_en (dv_upd_en),
        .dv_m      (dv_m),
        .dv_q      (dv_q),
        .ssr_val   (ssr_cur),
        .sr_o      (sr_cur),
        .priv_viol (priv_viol)
    );

    exc_save #(.ADDR_W(ADDR_W)) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_take (exc_take),
        .pc_in    (exc_pc),
        .sr_in    (sr_cur),
        .spc_o    (rte_pc),
        .ssr_o    (ssr_cur)
    );

    vbr_core #(.ADDR_W(ADDR_W), .VOFS_W(VOFS_W)) u_vbr (
        .clk          (clk),
        .rst_n        (rst_n),
        .priv         (sr_cur.priv),
        .vbr_wr_en    (vbr_wr_en),
        .vbr_wr_data  (vbr_wr_data),
        .vofs         (exc_vofs),
        .handler_addr (handler_addr)
    );

    irq_gate u_irq (
        .blk    (sr_cur.blk),
        .imask  (sr_cur.imask),
        .level  (irq_level),
        .accept (irq_accept)
    );

    assign sr_word   = sr_cur;
    assign flag_t    = sr_cur.t;
    assign flag_s    = sr_cur.s;
    assign flag_m    = sr_cur.m;
    assign flag_q    = sr_cur.q;
    assign int_mask  = sr_cur.imask;
    assign reg_bank  = sr_cur.bank;
    assign exc_block = sr_cur.blk;
    assign priv_mode = sr_cur.priv;

    // R4
    viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_viol && !sr_wr_en && !vbr_wr_en) |=> !priv_viol);
endmodule

// File: tb/tb_ctx_status_regs.sv
module tb_ctx_status_regs;
    localparam int AW = 16;
    localparam int VW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_take = 1'b0;
    logic [AW-1:0] exc_pc = '0;
    logic [VW-1:0] exc_vofs = '0;
    logic rte_go = 1'b0;
    logic sr_wr_en = 1'b0;
    logic [10:0] sr_wr_data = '0;
    logic vbr_wr_en = 1'b0;
    logic [AW-1:0] vbr_wr_data = '0;
    logic t_upd_en = 1'b0, t_upd_val = 1'b0;
    logic dv_upd_en = 1'b0, dv_m = 1'b0, dv_q = 1'b0;
    logic [3:0] irq_level = '0;

    logic [10:0] sr_word;
    logic flag_t, flag_s, flag_m, flag_q, reg_bank, exc_block, priv_mode;
    logic [3:0] int_mask;
    logic [AW-1:0] handler_addr, rte_pc;
    logic irq_accept, priv_viol;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    ctx_status_regs #(.ADDR_W(AW), .VOFS_W(VW)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sr_write(logic [10:0] v);
        sr_wr_en = 1'b1;
        sr_wr_data = v;
        tick();
        sr_wr_en = 1'b0;
    endtask

    task automatic take_exc(logic [AW-1:0] pc);
        exc_take = 1'b1;
        exc_pc = pc;
        tick();
        exc_take = 1'b0;
    endtask

    task automatic do_rte();
        rte_go = 1'b1;
        tick();
        rte_go = 1'b0;
    endtask

    task automatic fields(logic [10:0] v);
        chk("R2", {priv_mode, reg_bank, exc_block, int_mask, flag_m, flag_q, flag_s, flag_t}, v);
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", sr_word, 11'h7F0);
        fields(11'h7F0);
        chk("R1", handler_addr, 0);
        chk("R1", rte_pc, 0);
        chk("R1", priv_viol, 0);

        // R3 R2 R4 R5: all status encodings
        for (int v = 0; v < 2048; v++) begin
            sr_write(11'(v));
            chk("R3", sr_word, v);
            fields(11'(v));
            if (v[10] == 1'b0) begin
                sr_write(~11'(v));
                chk("R4", sr_word, v);
                chk("R4", priv_viol, 1);
                tick();
                chk("R4", priv_viol, 0);
                take_exc(AW'(v));
                chk("R5", sr_word, v | 11'h500);
                chk("R5", rte_pc, v);
            end
        end

        // R6: entry then return
        sr_write(11'h4A5);
        take_exc(16'h1234);
        chk("R5", sr_word, 11'h5A5);
        sr_write(11'h7F2);
        chk("R3", sr_word, 11'h7F2);
        do_rte();
        chk("R6", sr_word, 11'h4A5);
        chk("R6", rte_pc, 16'h1234);

        // R5 nested entry overwrites the single pair
        sr_write(11'h430);
        take_exc(16'h1111);
        sr_write(11'h461);
        take_exc(16'h2222);
        do_rte();
        chk("R5", sr_word, 11'h461);
        chk("R5", rte_pc, 16'h2222);

        // R7: exception and return together
        sr_write(11'h4C3);
        take_exc(16'h0ABC);
        sr_write(11'h402);
        exc_take = 1'b1; rte_go = 1'b1; exc_pc = 16'h5555;
        tick();
        exc_take = 1'b0; rte_go = 1'b0;
        chk("R7", sr_word, 11'h502);
        chk("R7", rte_pc, 16'h5555);
        // R7: exception beats SR write
        sr_write(11'h400);
        exc_take = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 11'h4FF; exc_pc = 16'h0001;
        tick();
        exc_take = 1'b0; sr_wr_en = 1'b0;
        chk("R7", sr_word, 11'h500);
        // R7: return beats SR write
        rte_go = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 11'h4FF;
        tick();
        rte_go = 1'b0; sr_wr_en = 1'b0;
        chk("R7", sr_word, 11'h400);

        // R10: flag updates in non-privileged mode
        sr_write(11'h000);
        for (int k = 0; k < 8; k++) begin
            t_upd_en = 1'b1; t_upd_val = k[0];
            dv_upd_en = k[2]; dv_m = k[1]; dv_q = ~k[1];
            tick();
            t_upd_en = 1'b0; dv_upd_en = 1'b0;
            chk("R10", flag_t, k[0]);
            if (k[2]) begin
                chk("R10", {flag_m, flag_q}, {k[1], ~k[1]});
            end
        end
        // R10: honoured write overrides flag update
        take_exc(16'h0);
        sr_write(11'h400);
        sr_wr_en = 1'b1; sr_wr_data = 11'h420; t_upd_en = 1'b1; t_upd_val = 1'b1;
        dv_upd_en = 1'b1; dv_m = 1'b1; dv_q = 1'b1;
        tick();
        sr_wr_en = 1'b0; t_upd_en = 1'b0; dv_upd_en = 1'b0;
        chk("R10", sr_word, 11'h420);

        // R11 R8: vector base and handler address
        for (int b = 0; b < 4; b++) begin
            logic [AW-1:0] base;
            base = (b == 0) ? 16'h0000 : (b == 1) ? 16'h0100 : (b == 2) ? 16'hFFF0 : 16'hFFFF;
            vbr_wr_en = 1'b1; vbr_wr_data = base;
            tick();
            vbr_wr_en = 1'b0;
            for (int o = 0; o < 256; o++) begin
                exc_vofs = VW'(o);
                #1;
                chk("R8", handler_addr, AW'(base + AW'(o)));
            end
        end
        exc_vofs = '0;
        #1;
        chk("R11", handler_addr, 16'hFFFF);
        // R4: VBR write outside privilege is dropped
        sr_write(11'h000);
        vbr_wr_en = 1'b1; vbr_wr_data = 16'h1200;
        tick();
        vbr_wr_en = 1'b0;
        chk("R4", handler_addr, 16'hFFFF);
        chk("R4", priv_viol, 1);
        take_exc(16'h0);

        // R9: interrupt gate sweep
        for (int bl = 0; bl < 2; bl++) begin
            for (int m = 0; m < 16; m++) begin
                sr_write(11'h400 | 11'(bl << 8) | 11'(m << 4));
                for (int l = 0; l < 16; l++) begin
                    irq_level = 4'(l);
                    #1;
                    chk("R9", irq_accept, (bl == 0) && (l > m));
                end
                if (bl == 1) begin
                    sr_write(11'h400);
                end
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule